// File: doc/BRIEF.md
# Divider and Programmable Timer

This block keeps time for a small processor that completes one machine cycle per clock. A free-running internal count advances on every cycle, and its upper byte is visible as an 8-bit divider. A second 8-bit counter advances at one of four rates chosen by a control register. When that counter passes 0xFF, it reloads from a modulo register and raises an interrupt request for one cycle.

Software reaches the four registers through a narrow register bus. Reads are combinational, and a write takes effect at the next clock edge. The halt input models the processor's stop and speed-switch conditions. While it is high, the divider is held at zero.

The timer does not count cycles directly. It steps when the AND of the run bit and the selected internal count bit falls from 1 to 0. Because of this, a control write or a divider clear can each add one extra step.

Top module: `tmr_unit`

## Requirements
- R1: While reset is low, and after it is released, every register reads zero, except that the control register reads 0xF8. irq_o is low.
- R2: Register address 0 is the divider. It reads bits 13:6 of a 14-bit count that advances once per clock, so it increments every 64 cycles. A write of any value clears the whole count.
- R3: While halt_i is high, the count is held at zero. Counting resumes on the first edge after halt_i falls.
- R4: Control bit 2 is the run bit. While it is 0, the timer counter (address 1) holds its value, and the divider keeps counting.
- R5: Control bits 1:0 select the step period: 00 steps every 256 cycles (count bit 7), 01 every 4 (bit 1), 10 every 16 (bit 3), 11 every 64 (bit 5). A step happens on the edge where the run bit ANDed with the selected bit goes from 1 to 0.
- R6: A step taken at 0xFF loads the modulo register (address 2) into the timer counter instead of wrapping. irq_o is then high for exactly the following cycle. With a modulo of 0xFF every step raises a request; with 0xFE every second step does.
- R7: If the modulo register is written on the same edge as a reload, the counter receives the value the modulo register held before that write.
- R8: A control write (address 3) that makes the ANDed step signal fall adds exactly one step. A control write that leaves it low adds none.
- R9: Clearing the count by a divider write, or by raising halt_i, while the ANDed step signal is high adds exactly one step.
- R10: The control register keeps only bits 2:0. Bits 7:3 always read as 1.
- R11: A write to the timer counter on the same edge as a step wins: the written value is stored and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | 1 | Holds and clears the internal count while high |
| addr_i | input | 2 | Register select: 0 divider, 1 counter, 2 modulo, 3 control |
| we_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register, combinational |
| irq_o | output | 1 | One-cycle interrupt request after a reload |

## Verification
The assertions assume that inputs change only between edges, and that every write and halt level is held for a whole cycle. The count checks assume that halt_i and a divider write are the only events that disturb the count. The bench applies all stimulus just after the falling edge, one register write per cycle. Before each rate or spurious-step case, it brings the count to a known phase by clearing the divider with the timer stopped, so every expected step lands on a cycle that can be computed in advance.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Register select codes on the bus.
    typedef enum logic [1:0] {
        REG_DIV = 2'd0,
        REG_CNT = 2'd1,
        REG_MOD = 2'd2,
        REG_CTL = 2'd3
    } reg_sel_e;

    // Stored control bits: run enable and rate select.
    typedef struct packed {
        logic       run;
        logic [1:0] rate;
    } ctl_t;

    localparam int CTL_W = 3;

    // Internal count bit watched for each rate code.
    function automatic logic [3:0] tap_index(input logic [1:0] rate);
        logic [3:0] idx;
        case (rate)
            2'b00:   idx = 4'd7;
            2'b01:   idx = 4'd1;
            2'b10:   idx = 4'd3;
            default: idx = 4'd5;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.cnt = cur_q.cnt + 1'b1;
        if (hold_i || clear_i) begin
            nxt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cnt_q_o = cur_q.cnt;
    assign cnt_d_o = nxt_d.cnt;

    p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (cnt_q_o == '0));

    p_div_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !clear_i) |=> (cnt_q_o == $past(cnt_q_o) + 1'b1));

endmodule

// File: rtl/tmr_step.sv
module tmr_step #(
    parameter int CNT_W = 14
) (
    input  tmr_pkg::ctl_t    ctl_cur_i,
    input  tmr_pkg::ctl_t    ctl_nxt_i,
    input  logic [CNT_W-1:0] cnt_cur_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    output logic             step_o
);
    localparam int IDX_W = $clog2(CNT_W);

    logic lvl_cur, lvl_nxt;

    // Step on the edge where the gated tap level drops.
    always_comb begin
        lvl_cur = ctl_cur_i.run & cnt_cur_i[IDX_W'(tmr_pkg::tap_index(ctl_cur_i.rate))];
        lvl_nxt = ctl_nxt_i.run & cnt_nxt_i[IDX_W'(tmr_pkg::tap_index(ctl_nxt_i.rate))];
        step_o  = lvl_cur & ~lvl_nxt;
    end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              cnt_we_i,
    input  logic              mod_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] mod_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] mod;
        logic              irq;
    } cnt_state_t;

    cnt_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.irq = 1'b0;
        if (step_i) begin
            if (cur_q.cnt == '1) begin
                nxt_d.cnt = cur_q.mod;   // old modulo even if rewritten now
                nxt_d.irq = 1'b1;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
        if (cnt_we_i) begin
            nxt_d.cnt = wdata_i;
            nxt_d.irq = 1'b0;
        end
        if (mod_we_i) begin
            nxt_d.mod = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cnt_o = cur_q.cnt;
    assign mod_o = cur_q.mod;
    assign irq_o = cur_q.irq;

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_reload_old_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (cnt_o == $past(mod_o)));

    p_cnt_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we_i |=> (cnt_o == $past(wdata_i)) && !irq_o);

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_i,
    input  logic [1:0]        addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    import tmr_pkg::*;

    localparam int DIV_LSB = CNT_W - DATA_W;
    localparam int PAD_W   = DATA_W - CTL_W;

    typedef struct packed {
        ctl_t ctl;
    } top_state_t;

    top_state_t cur_q, nxt_d;

    logic              wr_div, wr_cnt, wr_mod, wr_ctl;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              step;
    logic [DATA_W-1:0] tcnt, tmod;

    always_comb begin
        wr_div = we_i && (addr_i == REG_DIV);
        wr_cnt = we_i && (addr_i == REG_CNT);
        wr_mod = we_i && (addr_i == REG_MOD);
        wr_ctl = we_i && (addr_i == REG_CTL);
        nxt_d  = cur_q;
        if (wr_ctl) begin
            nxt_d.ctl = ctl_t'(wdata_i[CTL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    tmr_divider #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (wr_div),
        .hold_i  (halt_i),
        .cnt_q_o (cnt_q),
        .cnt_d_o (cnt_d)
    );

    tmr_step #(.CNT_W(CNT_W)) u_step (
        .ctl_cur_i (cur_q.ctl),
        .ctl_nxt_i (nxt_d.ctl),
        .cnt_cur_i (cnt_q),
        .cnt_nxt_i (cnt_d),
        .step_o    (step)
    );

    tmr_count #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .cnt_we_i (wr_cnt),
        .mod_we_i (wr_mod),
        .wdata_i  (wdata_i),
        .cnt_o    (tcnt),
        .mod_o    (tmod),
        .irq_o    (irq_o)
    );

    always_comb begin
        case (addr_i)
            REG_DIV: rdata_o = cnt_q[CNT_W-1:DIV_LSB];
            REG_CNT: rdata_o = tcnt;
            REG_MOD: rdata_o = tmod;
            default: rdata_o = {{PAD_W{1'b1}}, cur_q.ctl};
        endcase
    end

    p_div_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_div |=> (rdata_o == '0 || addr_i != REG_DIV) && (cnt_q == '0));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.ctl.run && !wr_ctl && !wr_cnt) |=> $stable(tcnt));

    p_ctl_pad_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == REG_CTL) |-> (rdata_o[DATA_W-1:CTL_W] == '1));

endmodule

// File: tb/tmr_unit_bench.sv
module tmr_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       halt_i;
    logic [1:0] addr_i;
    logic       we_i;
    logic [7:0] wdata_i;
    logic [7:0] rdata_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        int         kind;   // 0 register read, 1 irq level, 2 precomputed value
        logic [1:0] addr;
        logic [7:0] exp;
        logic [7:0] act;
        string      tag;
    } item_t;

    item_t sb[$];

    localparam logic [1:0] A_DIV = 2'd0, A_CNT = 2'd1, A_MOD = 2'd2, A_CTL = 2'd3;

    always #5 clk = ~clk;

    tmr_unit u_tmr_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt_i  (halt_i),
        .addr_i  (addr_i),
        .we_i    (we_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    // Monitor: pops expectations and compares against the ports.
    initial begin
        forever begin
            item_t it;
            logic [7:0] got;
            wait (sb.size() != 0);
            it = sb.pop_front();
            case (it.kind)
                0:       got = rdata_o;
                1:       got = {7'd0, irq_o};
                default: got = it.act;
            endcase
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [1:0] a, input logic [7:0] e,
                        input logic [7:0] act, input string tag);
        item_t it;
        it.kind = kind; it.addr = a; it.exp = e; it.act = act; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
        #1;
    endtask

    task automatic exp_reg(input logic [1:0] a, input logic [7:0] v, input string tag);
        addr_i = a;
        #1;
        push(0, a, v, 8'h00, tag);
    endtask

    task automatic exp_irq(input logic v, input string tag);
        #1;
        push(1, 2'd0, {7'd0, v}, 8'h00, tag);
    endtask

    task automatic exp_val(input logic [7:0] act, input logic [7:0] v, input string tag);
        push(2, 2'd0, v, act, tag);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        we_i = 1'b0;
    endtask

    // Timer stopped, counter and modulo loaded, count cleared, then control set.
    // Afterwards the internal count is 1.
    task automatic setup(input logic [1:0] rate, input logic [7:0] c0, input logic [7:0] m0);
        wr(A_CTL, 8'h00);
        wr(A_CNT, c0);
        wr(A_MOD, m0);
        wr(A_DIV, 8'h00);
        wr(A_CTL, {5'd0, 1'b1, rate});
    endtask

    task automatic rate_case(input logic [1:0] rate, input int period, input string tag);
        setup(rate, 8'h00, 8'h00);
        tick(3 * period - 2);
        exp_reg(A_CNT, 8'h02, {tag, " two steps"});
        tick(1);
        exp_reg(A_CNT, 8'h03, {tag, " third step on boundary"});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; halt_i = 1'b0; addr_i = 2'd0; we_i = 1'b0; wdata_i = 8'h00;
        tick(3);
        exp_reg(A_CTL, 8'hF8, "R1 control during reset");
        rst_n = 1'b1;
        exp_reg(A_DIV, 8'h00, "R1 divider");
        exp_reg(A_CNT, 8'h00, "R1 counter");
        exp_reg(A_MOD, 8'h00, "R1 modulo");
        exp_reg(A_CTL, 8'hF8, "R1 control");
        exp_irq(1'b0, "R1 irq");

        // R2: divider rate and clear
        wr(A_DIV, 8'h5A);
        tick(63);
        exp_reg(A_DIV, 8'h00, "R2 before 64 cycles");
        tick(1);
        exp_reg(A_DIV, 8'h01, "R2 at 64 cycles");
        tick(192);
        exp_reg(A_DIV, 8'h04, "R2 at 256 cycles");
        wr(A_DIV, 8'hFF);
        exp_reg(A_DIV, 8'h00, "R2 cleared by write");

        // R3: halt holds the count at zero
        tick(200);
        halt_i = 1'b1;
        tick(100);
        exp_reg(A_DIV, 8'h00, "R3 held during halt");
        halt_i = 1'b0;
        tick(63);
        exp_reg(A_DIV, 8'h00, "R3 63 cycles after release");
        tick(1);
        exp_reg(A_DIV, 8'h01, "R3 resumed");

        // R10: control padding
        wr(A_CTL, 8'h05);
        exp_reg(A_CTL, 8'hFD, "R10 write 05");
        wr(A_CTL, 8'h02);
        exp_reg(A_CTL, 8'hFA, "R10 write 02");

        // R5: all four rates
        rate_case(2'b01, 4,   "R5 rate01");
        rate_case(2'b10, 16,  "R5 rate10");
        rate_case(2'b11, 64,  "R5 rate11");
        rate_case(2'b00, 256, "R5 rate00");

        // R4: stopped timer, running divider
        wr(A_CTL, 8'h01);
        wr(A_CNT, 8'h33);
        wr(A_DIV, 8'h00);
        tick(128);
        exp_reg(A_CNT, 8'h33, "R4 counter held");
        exp_reg(A_DIV, 8'h02, "R4 divider runs");

        // R6: reload timing
        setup(2'b01, 8'hFF, 8'h00);
        tick(2);
        exp_irq(1'b0, "R6 no request before step");
        exp_reg(A_CNT, 8'hFF, "R6 counter before step");
        tick(1);
        exp_irq(1'b1, "R6 request after reload");
        exp_reg(A_CNT, 8'h00, "R6 reloaded from modulo");
        tick(1);
        exp_irq(1'b0, "R6 request one cycle");

        // R6: modulo FF gives a request on every step
        begin
            int n = 0;
            setup(2'b01, 8'hFF, 8'hFF);
            for (int e = 1; e <= 40; e++) begin
                tick(1);
                if (irq_o) n++;
            end
            exp_val(8'(n), 8'd10, "R6 modulo FF request count");
            exp_reg(A_CNT, 8'hFF, "R6 modulo FF counter");
        end
        // R6: modulo FE gives a request on every second step
        begin
            int n = 0;
            setup(2'b01, 8'hFE, 8'hFE);
            for (int e = 1; e <= 40; e++) begin
                tick(1);
                if (irq_o) n++;
            end
            exp_val(8'(n), 8'd5, "R6 modulo FE request count");
            exp_reg(A_CNT, 8'hFE, "R6 modulo FE counter");
        end

        // R7: modulo write on the reload edge
        setup(2'b01, 8'hFF, 8'h10);
        tick(2);
        wr(A_MOD, 8'h80);
        exp_reg(A_CNT, 8'h10, "R7 old modulo loaded");
        exp_reg(A_MOD, 8'h80, "R7 new modulo stored");
        exp_irq(1'b1, "R7 request raised");

        // R11: counter write on the step edge
        setup(2'b01, 8'hFF, 8'h10);
        tick(2);
        wr(A_CNT, 8'h77);
        exp_reg(A_CNT, 8'h77, "R11 write wins");
        exp_irq(1'b0, "R11 no request");

        // R8: control writes
        setup(2'b01, 8'h20, 8'h00);
        tick(1);
        wr(A_CTL, 8'h01);
        exp_reg(A_CNT, 8'h21, "R8 disable while tap high");
        tick(20);
        exp_reg(A_CNT, 8'h21, "R8 only one extra step");
        setup(2'b01, 8'h30, 8'h00);
        wr(A_CTL, 8'h01);
        exp_reg(A_CNT, 8'h30, "R8 disable while tap low");
        setup(2'b01, 8'h50, 8'h00);
        tick(1);
        wr(A_CTL, 8'h04);
        exp_reg(A_CNT, 8'h51, "R8 rate change drops level");

        // R9: count clear while tap high
        setup(2'b01, 8'h40, 8'h00);
        tick(1);
        wr(A_DIV, 8'h00);
        exp_reg(A_CNT, 8'h41, "R9 divider write step");
        exp_reg(A_DIV, 8'h00, "R9 divider cleared");
        setup(2'b01, 8'h60, 8'h00);
        tick(1);
        halt_i = 1'b1;
        tick(1);
        exp_reg(A_CNT, 8'h61, "R9 halt step");
        tick(10);
        exp_reg(A_CNT, 8'h61, "R9 no steps while halted");
        halt_i = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule